// File: doc/BRIEF.md
# Paged register address decoder

This block sits in front of a 64 KiB register aperture. A host request may be one, two or four bytes wide. The block turns it into single-byte accesses at ascending addresses, one per clock cycle. It steers each byte by the page, which is address bits [15:8]. Page 0 goes to a byte-wide system control bank on the external bus. Page 1 goes to a small configuration space held inside the block. Every other page goes to a byte-wide NAND register window, but only when that window is enabled and its base matches.

The configuration space holds the window enable and a 32-bit window base. Software writes the base one byte lane at a time, so the window can be moved anywhere in the aperture. Read bytes come back in little-endian order and are returned with a one-cycle done pulse. A busy flag refuses new requests while a split access is still in progress.

Top module: `paged_reg_decoder`

## Requirements
- R1: After reset, busy_o and done_o are 0, the window is disabled, and the window base is 0.
- R2: A byte whose address bits [15:8] are 0 is sent to the system control bank: scb_req_o is 1 and dn_ofs_o carries address bits [7:0]. A byte whose bits [15:8] are 1 goes to the configuration space, and no external strobe is raised for it.
- R3: Configuration offset 0x04 holds the window enable. A write sets the enable to write data bit 1 and ignores the other bits. A read returns 0x02 when the window is enabled and 0x00 when it is not.
- R4: Configuration offsets 0x10 to 0x13 hold window base bytes 0 to 3, least significant byte first. Each offset can be written on its own and read back.
- R5: A byte on any other page is sent to the NAND window only when two conditions hold: the window is enabled, and the byte address with bits [7:0] cleared, zero-extended to 32 bits, equals the base. Such a byte raises nand_req_o with dn_ofs_o equal to address bits [7:0].
- R6: A read byte that hits no target returns 0x00. A write byte that hits no target raises no strobe.
- R7: size_i encodes the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The bytes are issued on consecutive cycles at addr, addr+1, and so on. Byte k carries write data bits [8k+7:8k] and fills read data bits [8k+7:8k]. An access may cross a page boundary, and each byte is routed on its own.
- R8: An accepted request is issued as bytes in the N cycles after acceptance, and busy_o is high in those cycles. done_o is high for exactly one cycle, the cycle after the last byte. In that cycle rdata_o holds the assembled read data, or 0 after a write.
- R9: req_i is ignored while busy_o is high.
- R10: Pages 0 and 1 take priority over the NAND window, even when the base points at them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when busy_o is low |
| we_i | input | 1 | Request is a write |
| size_i | input | 2 | Access width code |
| addr_i | input | 16 | Byte address of the first byte |
| wdata_i | input | 32 | Write data, little-endian lanes |
| busy_o | output | 1 | A split access is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read data, valid with done_o |
| scb_req_o | output | 1 | Byte strobe to the system control bank |
| nand_req_o | output | 1 | Byte strobe to the NAND window |
| dn_we_o | output | 1 | Byte strobe is a write |
| dn_ofs_o | output | 8 | Byte offset within the page |
| dn_wdata_o | output | 8 | Write byte |
| scb_rdata_i | input | 8 | Read byte from the system control bank, same cycle |
| nand_rdata_i | input | 8 | Read byte from the NAND window, same cycle |

## Verification
The assertions assume the following:
- Both byte slaves return read data in the same cycle as the strobe.
- The host holds we_i, size_i, addr_i and wdata_i valid in the cycle where req_i is sampled with busy_o low.
- After a write to the enable register, that register is not written again in the next cycle, so the enable check compares against a single write.

The stimulus changes inputs only on the falling clock edge. A new request is raised only after the previous done pulse has been seen. The one exception is a request deliberately raised while busy_o is high, which exercises the ignored-request rule. The slave models answer combinationally from their byte arrays, so the same-cycle read assumption holds.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam logic [7:0] CFG_EN_OFS   = 8'h04;
  localparam logic [7:0] CFG_BASE_OFS = 8'h10;
  localparam int         CFG_EN_BIT   = 1;
endpackage

// File: rtl/prd_splitter.sv
module prd_splitter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [7:0]        bdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              b_vld_o,
  output logic              b_we_o,
  output logic [ADDR_W-1:0] b_addr_o,
  output logic [7:0]        b_wdata_o
);
  localparam int NB = DATA_W / 8;
  localparam int IW = $clog2(NB);

  logic              busy_q, done_q, we_q;
  logic [IW-1:0]     idx_q, last_q, last_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept;

  assign accept = req_i && !busy_q;

  always_comb begin
    case (size_i)
      2'd0:    last_d = '0;
      2'd1:    last_d = IW'(1);
      default: last_d = IW'(NB - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        we_q    <= we_i;
        idx_q   <= '0;
        last_q  <= last_d;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        rdata_q <= '0;
      end else if (busy_q) begin
        if (!we_q) rdata_q[{idx_q, 3'b000} +: 8] <= bdata_i;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign b_vld_o   = busy_q;
  assign b_we_o    = we_q;
  assign b_addr_o  = addr_q + ADDR_W'(idx_q);
  assign b_wdata_o = wdata_q[{idx_q, 3'b000} +: 8];

  // R8: completion only ends a busy period
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  // R9: a request during busy does not disturb the captured access
  p_hold_while_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/prd_cfg.sv
module prd_cfg #(
  parameter int BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [7:0]        ofs_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              win_en_o,
  output logic [BASE_W-1:0] win_base_o
);
  import prd_pkg::*;
  localparam int NL = BASE_W / 8;

  logic       en_q;
  logic [7:0] lane_rd [NL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                en_q <= 1'b0;
    else if (sel_i && we_i && ofs_i == CFG_EN_OFS) en_q <= wdata_i[CFG_EN_BIT];
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam logic [7:0] LOFS = CFG_BASE_OFS + 8'(l);
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lane_q <= '0;
      else if (sel_i && we_i && ofs_i == LOFS) lane_q <= wdata_i;
    end
    assign win_base_o[8*l +: 8] = lane_q;
    assign lane_rd[l] = (ofs_i == LOFS) ? lane_q : 8'h00;
  end

  always_comb begin
    rdata_o = '0;
    if (ofs_i == CFG_EN_OFS) rdata_o[CFG_EN_BIT] = en_q;
    for (int l = 0; l < NL; l++) rdata_o = rdata_o | lane_rd[l];
  end

  assign win_en_o = en_q;

  // R3: enable follows bit 1 of the written byte
  p_en_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && ofs_i == CFG_EN_OFS) |=> (win_en_o == $past(wdata_i[CFG_EN_BIT])));
endmodule

// File: rtl/prd_router.sv
module prd_router #(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              b_vld_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              win_en_i,
  input  logic [BASE_W-1:0] win_base_i,
  input  logic [7:0]        scb_rdata_i,
  input  logic [7:0]        cfg_rdata_i,
  input  logic [7:0]        nand_rdata_i,
  output logic              scb_req_o,
  output logic              cfg_sel_o,
  output logic              nand_req_o,
  output logic [7:0]        bdata_o
);
  localparam int PW = ADDR_W - 8;

  logic [PW-1:0]     page;
  logic [BASE_W-1:0] page_base;
  logic              win_hit;

  assign page = b_addr_i[ADDR_W-1:8];

  always_comb begin
    page_base = '0;
    page_base[ADDR_W-1:8] = page;
  end

  assign win_hit    = win_en_i && (page_base == win_base_i);
  assign scb_req_o  = b_vld_i && (page == PW'(0));
  assign cfg_sel_o  = b_vld_i && (page == PW'(1));
  assign nand_req_o = b_vld_i && (page > PW'(1)) && win_hit;

  always_comb begin
    if (scb_req_o)       bdata_o = scb_rdata_i;
    else if (cfg_sel_o)  bdata_o = cfg_rdata_i;
    else if (nand_req_o) bdata_o = nand_rdata_i;
    else                 bdata_o = 8'h00;
  end

  // R2: at most one target per byte
  p_one_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scb_req_o, cfg_sel_o, nand_req_o}));
  // R5: window strobe only while enabled
  p_nand_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_req_o |-> win_en_i);
  // R10: low pages never reach the window
  p_low_page_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_req_o |-> (b_addr_i[ADDR_W-1:8] > PW'(1)));
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              scb_req_o,
  output logic              nand_req_o,
  output logic              dn_we_o,
  output logic [7:0]        dn_ofs_o,
  output logic [7:0]        dn_wdata_o,
  input  logic [7:0]        scb_rdata_i,
  input  logic [7:0]        nand_rdata_i
);
  logic              b_vld, b_we, cfg_sel, win_en;
  logic [ADDR_W-1:0] b_addr;
  logic [7:0]        b_wdata, bdata, cfg_rdata;
  logic [BASE_W-1:0] win_base;

  prd_splitter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_split (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .wdata_i,
    .bdata_i(bdata), .busy_o, .done_o, .rdata_o,
    .b_vld_o(b_vld), .b_we_o(b_we), .b_addr_o(b_addr), .b_wdata_o(b_wdata)
  );

  prd_router #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_route (
    .clk_i, .rst_ni, .b_vld_i(b_vld), .b_addr_i(b_addr),
    .win_en_i(win_en), .win_base_i(win_base),
    .scb_rdata_i, .cfg_rdata_i(cfg_rdata), .nand_rdata_i,
    .scb_req_o, .cfg_sel_o(cfg_sel), .nand_req_o, .bdata_o(bdata)
  );

  prd_cfg #(.BASE_W(BASE_W)) u_cfg (
    .clk_i, .rst_ni, .sel_i(cfg_sel), .we_i(b_we), .ofs_i(b_addr[7:0]),
    .wdata_i(b_wdata), .rdata_o(cfg_rdata), .win_en_o(win_en), .win_base_o(win_base)
  );

  assign dn_we_o    = b_we;
  assign dn_ofs_o   = b_addr[7:0];
  assign dn_wdata_o = b_wdata;
endmodule

// File: tb/paged_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module paged_reg_decoder_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = '0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        busy_o, done_o, scb_req_o, nand_req_o, dn_we_o;
  logic [31:0] rdata_o;
  logic [7:0]  dn_ofs_o, dn_wdata_o, scb_rdata, nand_rdata;

  logic [7:0]  scb_mem [256];
  logic [7:0]  nand_mem [256];
  logic [9:0]  slog [$];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  paged_reg_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .busy_o, .done_o, .rdata_o,
    .scb_req_o, .nand_req_o, .dn_we_o, .dn_ofs_o, .dn_wdata_o,
    .scb_rdata_i(scb_rdata), .nand_rdata_i(nand_rdata)
  );

  assign scb_rdata  = scb_mem[dn_ofs_o];
  assign nand_rdata = nand_mem[dn_ofs_o];

  always @(posedge clk) if (rst_n && (scb_req_o || nand_req_o)) begin
    slog.push_back({nand_req_o, dn_we_o, dn_ofs_o});
    if (dn_we_o && scb_req_o)  scb_mem[dn_ofs_o]  = dn_wdata_o;
    if (dn_we_o && nand_req_o) nand_mem[dn_ofs_o] = dn_wdata_o;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) if (rst_n && done_o) begin
    if (exp_q.size() == 0) check(0, "R8 unexpected done", 32'd1, 32'd0);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(rdata_o === e, t, rdata_o, e);
    end
  end

  task automatic acc(input bit w, input logic [1:0] sz, input logic [15:0] a,
                     input logic [31:0] d, input logic [31:0] e, input string t);
    automatic int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    automatic int cnt = 0;
    while (busy_o) @(negedge clk);
    exp_q.push_back(w ? 32'h0 : e);
    tag_q.push_back(t);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 12) begin
      check(busy_o === 1'b1, "R8 busy during bytes", 32'(busy_o), 32'd1);
      @(negedge clk);
      cnt++;
    end
    check(cnt == nb + 1, "R8 completion latency", 32'(cnt), 32'(nb + 1));
    @(negedge clk);
  endtask

  function automatic int n_nand();
    int n = 0;
    foreach (slog[i]) if (slog[i][9]) n++;
    return n;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    foreach (scb_mem[i]) begin scb_mem[i] = 8'h00; nand_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(0, 2'd0, 16'h0104, 0, 32'h0, "R1 R3 enable clear at reset");
    acc(0, 2'd2, 16'h0110, 0, 32'h0, "R1 R4 base zero at reset");

    // system control bank, split ordering
    slog.delete();
    acc(1, 2'd2, 16'h0020, 32'hA1B2C3D4, 0, "R2 scb word write");
    check(slog.size() == 4, "R7 four strobes", slog.size(), 4);
    for (int k = 0; k < 4; k++)
      if (slog.size() > k)
        check(slog[k] == {2'b01, 8'(8'h20 + k)}, "R7 byte order", slog[k], {2'b01, 8'(8'h20 + k)});
    check({scb_mem[8'h23], scb_mem[8'h22], scb_mem[8'h21], scb_mem[8'h20]} == 32'hA1B2C3D4,
          "R2 R7 scb lanes", {scb_mem[8'h23], scb_mem[8'h22], scb_mem[8'h21], scb_mem[8'h20]}, 32'hA1B2C3D4);
    acc(0, 2'd1, 16'h0021, 0, 32'h0000B2C3, "R7 half read");
    acc(0, 2'd0, 16'h0023, 0, 32'h000000A1, "R2 byte read");
    acc(0, 2'd3, 16'h0020, 0, 32'hA1B2C3D4, "R7 size 3 is word");

    // unmatched accesses while disabled
    slog.delete();
    acc(0, 2'd2, 16'h3400, 0, 32'h0, "R6 unmatched read zero");
    acc(1, 2'd2, 16'h3400, 32'hFFFFFFFF, 0, "R6 unmatched write");
    check(slog.size() == 0, "R6 no strobe unmatched", slog.size(), 0);

    // base programming
    acc(1, 2'd2, 16'h0110, 32'h00003400, 0, "R4 base write");
    acc(0, 2'd2, 16'h0110, 0, 32'h00003400, "R4 base readback");
    acc(0, 2'd0, 16'h0111, 0, 32'h00000034, "R4 base lane 1");
    acc(1, 2'd0, 16'h0113, 32'h000000C7, 0, "R4 single lane write");
    acc(0, 2'd2, 16'h0110, 0, 32'hC7003400, "R4 lane 3 only");
    acc(1, 2'd0, 16'h0113, 32'h00000000, 0, "R4 lane 3 clear");
    slog.delete();
    acc(1, 2'd0, 16'h3410, 32'h55, 0, "R5 disabled window write");
    check(n_nand() == 0, "R5 no strobe while disabled", n_nand(), 0);

    // enable register
    acc(1, 2'd0, 16'h0104, 32'hFD, 0, "R3 write without bit 1");
    acc(0, 2'd0, 16'h0104, 0, 32'h00, "R3 bit 1 only");
    acc(1, 2'd0, 16'h0104, 32'h02, 0, "R3 enable write");
    acc(0, 2'd0, 16'h0104, 0, 32'h02, "R3 enable reads 2");

    // window hits
    slog.delete();
    acc(1, 2'd2, 16'h3410, 32'h11223344, 0, "R5 window write");
    check(n_nand() == 4, "R5 window strobes", n_nand(), 4);
    check({nand_mem[8'h13], nand_mem[8'h12], nand_mem[8'h11], nand_mem[8'h10]} == 32'h11223344,
          "R5 window lanes", {nand_mem[8'h13], nand_mem[8'h12], nand_mem[8'h11], nand_mem[8'h10]}, 32'h11223344);
    acc(0, 2'd1, 16'h3412, 0, 32'h00001122, "R5 window read");
    slog.delete();
    acc(0, 2'd0, 16'h3510, 0, 32'h0, "R6 other page miss");
    check(slog.size() == 0, "R6 no strobe other page", slog.size(), 0);

    // page crossing split
    acc(1, 2'd1, 16'h00FE, 32'h00009A8B, 0, "R7 write at page end");
    acc(0, 2'd2, 16'h00FE, 0, 32'h00009A8B, "R7 crossing into cfg");

    // upper base bits must match too
    acc(1, 2'd0, 16'h0112, 32'h01, 0, "R5 base upper byte");
    slog.delete();
    acc(0, 2'd0, 16'h3410, 0, 32'h0, "R5 upper base mismatch");
    check(slog.size() == 0, "R5 no strobe mismatch", slog.size(), 0);

    // base aimed at page 0
    acc(1, 2'd2, 16'h0110, 32'h00000000, 0, "R10 base zero");
    slog.delete();
    acc(1, 2'd0, 16'h0030, 32'h6E, 0, "R10 page 0 write");
    check(n_nand() == 0 && scb_mem[8'h30] == 8'h6E, "R10 page 0 wins",
          {n_nand(), scb_mem[8'h30]}, 32'h6E);

    // request while busy
    slog.delete();
    while (busy_o) @(negedge clk);
    exp_q.push_back(32'hA1B2C3D4); tag_q.push_back("R9 word read");
    req = 1; we = 0; size = 2'd2; addr = 16'h0020;
    @(negedge clk);
    we = 1; size = 2'd0; addr = 16'h0055; wdata = 32'hEE;
    @(negedge clk);
    req = 0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(slog.size() == 4, "R9 busy request ignored", slog.size(), 4);
    check(scb_mem[8'h55] == 8'h00, "R9 no stray write", scb_mem[8'h55], 0);
    check(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule